// File: doc/BRIEF.md
# Timer Tick-Source Selector with Prescaler and Reload Counter

This block is the front end of a single-channel up-counting timer. Each bus-clock cycle it decides whether a tick is present. In the bus-clock modes, every enabled cycle is a tick. In event-counting mode, a tick is a detected rising edge on one trigger line, chosen by a select field. The ticks advance a prescaler. Each time the prescaler wraps, the main counter advances once. The main counter runs from zero up to a reload value, wraps to zero there and raises a one-cycle update pulse.

Software can request an update at any time. The request clears both stages and raises the same update pulse. When event-counting mode is paired with the select code for the software bit, the timer stops counting, and the software request is then the only thing that moves it.

All logic runs on the bus clock. The trigger input passes through a synchronizer, and every tick acts as a clock enable. The counter value, the update pulse and both tick strobes come straight from registers, and they change together on the same edge.

Top module: `tmr_clksel_top`

## Requirements
- R1: A synchronous active-high `rst` clears the prescaler, the counter, the synchronizer and edge-detector state, and all outputs. `cnt_q`, `upd_evt`, `psc_tick` and `cnt_tick` read 0 on the cycle after reset.
- R2: For `slave_mode` values 0 through 6, the bus clock is the tick source. Each cycle with `en` high advances the prescaler, and `psc_tick` is high in the following cycle.
- R3: For `slave_mode` 7 with a nonzero `trig_sel` k, one tick is produced per rising edge of `trig_in[k-1]`. The tick appears as `psc_tick` three cycles after the input rises, because the input passes two synchronizer flops and one output register. A line held high gives only one tick. Lines that are not selected have no effect.
- R4: `slave_mode` 7 with `trig_sel` 0 selects the software bit as the trigger. In that combination no tick is produced, so the counter does not step, and `sw_upd` produces updates.
- R5: The prescaler counts from 0 up to `psc_val` and then wraps. Each wrap advances the counter once and raises `cnt_tick`, so `cnt_tick` fires once per `psc_val`+1 ticks.
- R6: The counter counts from 0 up to `reload_val`. On the step taken while it holds `reload_val`, it returns to 0 and `upd_evt` is high for exactly that one cycle. After N ticks from a cleared state, `cnt_q` equals floor(N/(`psc_val`+1)) mod (`reload_val`+1).
- R7: A cycle with `sw_upd` high clears the prescaler and the counter whatever the state of `en`. In the next cycle `upd_evt` is high, `cnt_q` is 0 and no tick strobe is high.
- R8: While `en` is low, both stages hold their values and no tick strobe fires.
- R9: `cnt_tick` is high in the same cycle that `cnt_q` shows the new count. That new count is the previous value plus one, unless `upd_evt` reports a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low freezes both stages |
| trig_in | input | NUM_TRIG | Event trigger lines, asynchronous |
| sw_upd | input | 1 | Software update request, one cycle per request |
| slave_mode | input | 3 | Slave-mode select; 7 is event counting |
| trig_sel | input | 3 | Trigger select; 0 is the software bit, k picks trig_in[k-1] |
| psc_val | input | PSC_W | Prescaler terminal value |
| reload_val | input | CNT_W | Counter reload (terminal) value |
| cnt_q | output | CNT_W | Main counter value |
| upd_evt | output | 1 | One-cycle update event pulse |
| psc_tick | output | 1 | Strobe: prescaler advanced |
| cnt_tick | output | 1 | Strobe: counter advanced |

## Verification
The properties assume that `psc_val` and `reload_val` are stable while the timer counts, and that `sw_upd` is low while reset is asserted. They also assume that `trig_sel` and `slave_mode` change only while every trigger line is low, because switching the selection onto a high line would be seen as a real edge. The stimulus obeys all of this. Configuration is written only while `en` is low, and a software update follows each write. Trigger pulses last two cycles high and two cycles low on the selected line. Noise pulses on an unselected line fall only in the gaps between those pulses.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 3;

  // slave-mode code that turns on event counting
  localparam logic [MODE_W-1:0] SMODE_EVENT = 3'd7;
  // trigger-select code naming the software update bit
  localparam logic [SEL_W-1:0]  TSEL_SOFT   = 3'd0;

  typedef enum logic [1:0] {
    SRC_BUSCLK = 2'd0,
    SRC_EDGE   = 2'd1,
    SRC_NONE   = 2'd2
  } tick_src_e;

  function automatic tick_src_e pick_source(input logic [MODE_W-1:0] mode,
                                            input logic [SEL_W-1:0]  sel);
    if (mode != SMODE_EVENT) return SRC_BUSCLK;
    if (sel == TSEL_SOFT)    return SRC_NONE;
    return SRC_EDGE;
  endfunction
endpackage

// File: rtl/tmr_trig_edge.sv
module tmr_trig_edge
  import tmr_clk_pkg::*;
#(
  parameter int NUM_TRIG    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    trig_sel,
  output logic                rise
);
  logic                   picked;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // select code k picks line k-1; code 0 picks nothing
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (trig_sel == SEL_W'(i + 1)) picked = trig_in[i];
    end
  end

  // synchronizer chain, one flop per stage
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= picked;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= 1'b0;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_div_stage.sv
module tmr_div_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wrap,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)     q <= '0;
    else if (step) begin
      if (wrap)         q <= '0;
      else              q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_clksel_top.sv
module tmr_clksel_top
  import tmr_clk_pkg::*;
#(
  parameter int NUM_TRIG    = 7,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 16,
  parameter int CNT_W       = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                sw_upd,
  input  logic [MODE_W-1:0]   slave_mode,
  input  logic [SEL_W-1:0]    trig_sel,
  input  logic [PSC_W-1:0]    psc_val,
  input  logic [CNT_W-1:0]    reload_val,
  output logic [CNT_W-1:0]    cnt_q,
  output logic                upd_evt,
  output logic                psc_tick,
  output logic                cnt_tick
);
  tick_src_e        src;
  logic             edge_tick;
  logic             src_tick;
  logic             psc_step, psc_wrap;
  logic             cnt_step, cnt_wrap;
  logic [PSC_W-1:0] psc_cur;

  tmr_trig_edge #(
    .NUM_TRIG    (NUM_TRIG),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .trig_sel (trig_sel),
    .rise     (edge_tick)
  );

  // tick source: bus clock, detected edge, or none (software trigger in event mode)
  always_comb begin
    src = pick_source(slave_mode, trig_sel);
    unique case (src)
      SRC_BUSCLK: src_tick = 1'b1;
      SRC_EDGE:   src_tick = edge_tick;
      default:    src_tick = 1'b0;
    endcase
  end

  // software update overrides any step in the same cycle
  assign psc_step = en & src_tick & ~sw_upd;
  assign psc_wrap = psc_cur >= psc_val;
  assign cnt_step = psc_step & psc_wrap;
  assign cnt_wrap = cnt_q >= reload_val;

  tmr_div_stage #(.W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .step (psc_step),
    .wrap (psc_wrap),
    .clr  (sw_upd),
    .q    (psc_cur)
  );

  tmr_div_stage #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .step (cnt_step),
    .wrap (cnt_wrap),
    .clr  (sw_upd),
    .q    (cnt_q)
  );

  // strobes registered so they line up with the new counter value
  always_ff @(posedge clk) begin
    if (rst) begin
      upd_evt  <= 1'b0;
      psc_tick <= 1'b0;
      cnt_tick <= 1'b0;
    end else begin
      upd_evt  <= sw_upd | (cnt_step & cnt_wrap);
      psc_tick <= psc_step;
      cnt_tick <= cnt_step;
    end
  end
endmodule

// File: rtl/tmr_clksel_chk.sv
module tmr_clksel_chk
  import tmr_clk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              sw_upd,
  input logic [MODE_W-1:0] slave_mode,
  input logic [SEL_W-1:0]  trig_sel,
  input logic [CNT_W-1:0]  reload_val,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              upd_evt,
  input logic              psc_tick,
  input logic              cnt_tick
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0 && !upd_evt && !psc_tick && !cnt_tick));

  // R2
  busclk_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(slave_mode) != SMODE_EVENT && !$past(sw_upd) && !$past(rst))
      |-> psc_tick);

  // R4
  soft_sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(slave_mode) == SMODE_EVENT && $past(trig_sel) == TSEL_SOFT && !$past(rst))
      |-> !psc_tick);

  // R5
  cnt_needs_psc_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_tick |-> psc_tick);

  // R6
  wrap_update_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_evt && !$past(sw_upd) && !$past(rst))
      |-> (cnt_q == '0 && $past(cnt_q) >= $past(reload_val)));

  // R7
  soft_update_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_upd) && !$past(rst)) |-> (upd_evt && cnt_q == '0 && !psc_tick));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(sw_upd) && !$past(rst))
      |-> ($stable(cnt_q) && !psc_tick && !cnt_tick));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !upd_evt) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

bind tmr_clksel_top tmr_clksel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .sw_upd     (sw_upd),
  .slave_mode (slave_mode),
  .trig_sel   (trig_sel),
  .reload_val (reload_val),
  .cnt_q      (cnt_q),
  .upd_evt    (upd_evt),
  .psc_tick   (psc_tick),
  .cnt_tick   (cnt_tick)
);

// File: tb/sim_tmr_clksel_top.sv
module sim_tmr_clksel_top;
  localparam int CLK_NS = 10;
  localparam int NT     = 7;
  localparam int PW     = 16;
  localparam int CW     = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [NT-1:0] trig_in = '0;
  logic          sw_upd = 1'b0;
  logic [2:0]    slave_mode = 3'd0;
  logic [2:0]    trig_sel = 3'd0;
  logic [PW-1:0] psc_val = '0;
  logic [CW-1:0] reload_val = '0;
  logic [CW-1:0] cnt_q;
  logic          upd_evt, psc_tick, cnt_tick;

  int n_vec = 0, n_bad = 0;
  int n_psc = 0, n_cnt = 0, n_upd = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tmr_clksel_top #(.NUM_TRIG(NT), .PSC_W(PW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .en(en), .trig_in(trig_in), .sw_upd(sw_upd),
    .slave_mode(slave_mode), .trig_sel(trig_sel), .psc_val(psc_val),
    .reload_val(reload_val), .cnt_q(cnt_q), .upd_evt(upd_evt),
    .psc_tick(psc_tick), .cnt_tick(cnt_tick));

  // strobe tallies: values held over the previous cycle, read at the edge
  always @(posedge clk) begin
    if (!rst) begin
      n_psc <= n_psc + int'(psc_tick);
      n_cnt <= n_cnt + int'(cnt_tick);
      n_upd <= n_upd + int'(upd_evt);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R7: software update clears both stages and pulses the update output
  task automatic soft_clear();
    @(negedge clk) sw_upd = 1'b1;
    @(negedge clk) sw_upd = 1'b0;
    chk("R7 upd_evt after sw_upd", upd_evt, 1);
    chk("R7 cnt_q after sw_upd", cnt_q, 0);
    @(negedge clk);
  endtask

  task automatic run_internal(input int mode, input int p, input int r, input int n);
    int s_p, s_c, s_u;
    @(negedge clk);
    en = 1'b0; slave_mode = 3'(mode); trig_sel = 3'(mode);
    psc_val = PW'(p); reload_val = CW'(r);
    soft_clear();
    s_p = n_psc; s_c = n_cnt; s_u = n_upd;
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 psc ticks in bus-clock mode", n_psc - s_p, n);
    chk("R5 cnt ticks per prescale", n_cnt - s_c, n / (p + 1));
    chk("R6 counter value", cnt_q, (n / (p + 1)) % (r + 1));
    chk("R6 update pulses", n_upd - s_u, n / ((p + 1) * (r + 1)));
  endtask

  task automatic run_event(input int sel, input int p, input int r, input int m);
    int s_p, s_u, nz;
    nz = sel % NT;
    @(negedge clk);
    en = 1'b0; slave_mode = 3'd7; trig_sel = 3'(sel);
    psc_val = PW'(p); reload_val = CW'(r);
    soft_clear();
    s_p = n_psc; s_u = n_upd;
    en = 1'b1;
    for (int k = 0; k < m; k++) begin
      trig_in[sel-1] = 1'b1;
      repeat (2) @(negedge clk);
      trig_in[sel-1] = 1'b0;
      trig_in[nz] = 1'b1;
      repeat (2) @(negedge clk);
      trig_in[nz] = 1'b0;
    end
    repeat (6) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R3 one tick per selected edge", n_psc - s_p, m);
    chk("R3 counter from edges", cnt_q, (m / (p + 1)) % (r + 1));
    chk("R6 update pulses in event mode", n_upd - s_u, m / ((p + 1) * (r + 1)));
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int s_p, keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 cnt_q after reset", cnt_q, 0);
    chk("R1 upd_evt after reset", upd_evt, 0);
    chk("R1 psc_tick after reset", psc_tick, 0);
    chk("R1 cnt_tick after reset", cnt_tick, 0);

    // R2, R5, R6: all bus-clock modes, small prescale and reload sweep
    for (int md = 0; md < 7; md++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 4; r++)
          run_internal(md, p, r, 37 + p);

    // R3: every selectable line, small prescale and reload sweep
    for (int sel = 1; sel <= NT; sel++)
      for (int p = 0; p < 3; p++)
        for (int r = 0; r < 3; r++)
          run_event(sel, p, r, 11);

    // R3: latency of one edge through synchronizer and register, held level ticks once
    @(negedge clk);
    slave_mode = 3'd7; trig_sel = 3'd3; psc_val = '0; reload_val = CW'(100);
    soft_clear();
    en = 1'b1;
    trig_in[2] = 1'b1;
    @(negedge clk); chk("R3 no tick at +1", psc_tick, 0);
    @(negedge clk); chk("R3 no tick at +2", psc_tick, 0);
    @(negedge clk); chk("R3 tick at +3", psc_tick, 1);
    chk("R9 cnt_q with tick", cnt_q, 1);
    chk("R9 cnt_tick with tick", cnt_tick, 1);
    @(negedge clk); chk("R3 held level no retick", psc_tick, 0);
    repeat (4) @(negedge clk);
    chk("R3 held level count", cnt_q, 1);
    trig_in[2] = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);

    // R4: software bit selected in event mode never counts
    slave_mode = 3'd7; trig_sel = 3'd0; psc_val = '0; reload_val = CW'(50);
    soft_clear();
    s_p = n_psc;
    en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      trig_in = '1; repeat (2) @(negedge clk);
      trig_in = '0; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R4 no ticks with software trigger", n_psc - s_p, 0);
    chk("R4 counter idle", cnt_q, 0);
    sw_upd = 1'b1;
    @(negedge clk) sw_upd = 1'b0;
    chk("R4 sw_upd issues update", upd_evt, 1);
    en = 1'b0;
    @(negedge clk);

    // R8: freeze with en low, then R7: software update while frozen
    slave_mode = 3'd0; trig_sel = 3'd1; psc_val = '0; reload_val = CW'(15);
    soft_clear();
    en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    keep = int'(cnt_q);
    chk("R8 count before freeze", keep, 5);
    s_p = n_psc;
    repeat (10) @(negedge clk);
    chk("R8 frozen counter", cnt_q, keep);
    chk("R8 no ticks while frozen", n_psc - s_p, 0);
    sw_upd = 1'b1;
    @(negedge clk) sw_upd = 1'b0;
    chk("R7 update with en low", upd_evt, 1);
    chk("R7 cleared with en low", cnt_q, 0);

    // R1: reset in the middle of counting
    en = 1'b1;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    en = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset clears counter", cnt_q, 0);
    chk("R1 mid-run reset clears strobe", psc_tick, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule